// File: doc/BRIEF.md
# Interconnect Channel-Filtered Event Counter

This block counts one selected kind of interconnect event. Each event arrives with a valid strobe, an event code, a 3-bit transaction-channel code, a trace-tag bit and a 2-bit ring indication. A configuration word picks the event code to count and sets three independent qualifiers: a channel filter, a trace-tag gate and a ring filter. The ring filter applies only to a fixed window of event codes.

Software-side logic reaches the block through a small register port with four word addresses: configuration, control, and the low and high halves of the counter. Reads are combinational on the address. Writes take effect at the next rising clock edge. The counter is 48 bits wide by default. When it wraps, a sticky overflow flag is set.

Top module: `noc_chan_evt_counter`

## Requirements
- R1: After reset, the counter, the overflow flag, the configuration word and the enable bit are all zero, so every address reads 0.
- R2: Address 0 holds the configuration: the event select in bits [7:0], the channel filter in [18:16], the trace-tag enable in bit 19 and the ring filter in [21:20]. All other bits read 0. Address 1 bit 0 is the enable and reads back; bit 1 is a write-only clear and reads 0. Address 2 returns count bits [31:0]. Address 3 returns count bits [47:32] in [15:0] and the overflow flag in bit 31.
- R3: While enabled, each cycle with evt_valid high whose code equals the event select and that passes every filter adds exactly 1. The new value is readable in the cycle after the capturing edge.
- R4: A channel filter of 0 disables channel filtering. The values 2 (request), 4 (snoop), 6 (response) and 7 (data) count only events whose channel code equals the filter. The values 1, 3 and 5 match no event.
- R5: When the trace-tag enable is 1, only events with evt_tag high are counted. When it is 0, the tag is ignored.
- R6: The ring indication uses bit 0 for the extended ring and bit 1 for the normal ring. Ring filter 01 or 11 counts events with bit 0 set. Filter 10 counts events with bit 1 set. Filter 00 counts events on either ring.
- R7: The ring filter is applied only to event codes 0x47 through 0x59 inclusive. Events with codes outside that window are counted whatever the ring filter holds.
- R8: When the enable is 0, events do not change the counter.
- R9: A control write with bit 1 set zeroes the counter and the overflow flag at the next edge. This takes priority over an event counted in the same cycle.
- R10: A counted event when the counter is all ones wraps it to 0 and sets the overflow flag. The flag stays set until a clear.
- R11: Events whose code differs from the event select do not change the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_code | input | CODE_W (8) | Event code |
| evt_chan | input | 3 | Transaction channel code |
| evt_tag | input | 1 | Trace tag of the transaction |
| evt_ring | input | 2 | Ring indication: bit 0 extended, bit 1 normal |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |

## Verification
An event or a control write presented before a rising edge is captured at that edge. Because reads are combinational, the result is visible one cycle after the stimulus. The bench drives every input on the falling edge and holds it for one full cycle. It then samples reg_rdata on a later falling edge, after letting the address settle, so each read falls one half-cycle after the capturing edge. For the same-cycle case of R9, the clear and a matching event are driven on the same falling edge. The result is then read after that single capturing edge.

// File: rtl/noc_chan_evt_counter.sv
module noc_chan_evt_counter #(
  parameter int CNT_W  = 48,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] RING_LO = 8'h47,
  parameter logic [CODE_W-1:0] RING_HI = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [2:0]        evt_chan,
  input  logic              evt_tag,
  input  logic [1:0]        evt_ring,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int CHF_LSB = 16;
  localparam int TAG_BIT = 19;
  localparam int RGF_LSB = 20;

  logic [CODE_W-1:0] sel_q;
  logic [2:0]        chf_q;
  logic              tag_en_q;
  logic [1:0]        rgf_q;
  logic              en_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;

  logic cfg_wr, ctl_wr, clr;
  logic chan_ok, tag_ok, in_win, ring_ok, hit;
  logic [63:0] cnt_ext;
  logic [31:0] cfg_word;

  assign cfg_wr = reg_wr && (reg_addr == 2'd0);
  assign ctl_wr = reg_wr && (reg_addr == 2'd1);
  assign clr    = ctl_wr && reg_wdata[1];

  always_comb begin
    case (chf_q)
      3'b000:                         chan_ok = 1'b1;
      3'b010, 3'b100, 3'b110, 3'b111: chan_ok = (evt_chan == chf_q);
      default:                        chan_ok = 1'b0;
    endcase
  end

  assign tag_ok  = !tag_en_q || evt_tag;
  assign in_win  = (evt_code >= RING_LO) && (evt_code <= RING_HI);

  always_comb begin
    case (rgf_q)
      2'b00:   ring_ok = 1'b1;
      2'b10:   ring_ok = evt_ring[1];
      default: ring_ok = evt_ring[0];
    endcase
    if (!in_win) ring_ok = 1'b1;
  end

  assign hit = evt_valid && en_q && (evt_code == sel_q) && chan_ok && tag_ok && ring_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      chf_q    <= '0;
      tag_en_q <= 1'b0;
      rgf_q    <= '0;
      en_q     <= 1'b0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (cfg_wr) begin
        sel_q    <= reg_wdata[CODE_W-1:0];
        chf_q    <= reg_wdata[CHF_LSB +: 3];
        tag_en_q <= reg_wdata[TAG_BIT];
        rgf_q    <= reg_wdata[RGF_LSB +: 2];
      end
      if (ctl_wr) en_q <= reg_wdata[0];
      if (clr) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (hit) begin
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) ovf_q <= 1'b1;
      end
    end
  end

  assign cnt_ext = 64'(cnt_q);

  always_comb begin
    cfg_word = '0;
    cfg_word[CODE_W-1:0]     = sel_q;
    cfg_word[CHF_LSB +: 3]   = chf_q;
    cfg_word[TAG_BIT]        = tag_en_q;
    cfg_word[RGF_LSB +: 2]   = rgf_q;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = cfg_word;
      2'd1:    reg_rdata = {31'b0, en_q};
      2'd2:    reg_rdata = cnt_ext[31:0];
      default: reg_rdata = {ovf_q, 15'b0, cnt_ext[47:32]};
    endcase
  end
endmodule

module chk_noc_chan_evt_counter #(
  parameter int CNT_W  = 48,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [CODE_W-1:0] evt_code,
  input logic              evt_tag,
  input logic [CODE_W-1:0] sel_q,
  input logic [2:0]        chf_q,
  input logic              tag_en_q,
  input logic              en_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              ovf_q
);
  logic clr_req;
  assign clr_req = reg_wr && (reg_addr == 2'd1) && reg_wdata[1];

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (cnt_q == '0) && !ovf_q);

  p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr_req) |=> $stable(cnt_q));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_other_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_code != sel_q) && !clr_req) |=> $stable(cnt_q));

  p_unlisted_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((chf_q == 3'd1 || chf_q == 3'd3 || chf_q == 3'd5) && !clr_req) |=> $stable(cnt_q));

  p_tag_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_en_q && !evt_tag && !clr_req) |=> $stable(cnt_q));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_req) |=> ovf_q);
endmodule

bind noc_chan_evt_counter chk_noc_chan_evt_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .evt_code(evt_code), .evt_tag(evt_tag), .sel_q(sel_q), .chf_q(chf_q),
  .tag_en_q(tag_en_q), .en_q(en_q), .cnt_q(cnt_q), .ovf_q(ovf_q)
);

// File: tb/test_noc_chan_evt_counter.sv
`timescale 1ns/1ps
module test_noc_chan_evt_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [7:0]  evt_code = '0;
  logic [2:0]  evt_chan = '0;
  logic        evt_tag = 1'b0;
  logic [1:0]  evt_ring = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  noc_chan_evt_counter i_noc_chan_evt_counter (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_chan(evt_chan), .evt_tag(evt_tag), .evt_ring(evt_ring), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata));

  noc_chan_evt_counter #(.CNT_W(6)) i_noc_chan_evt_counter_narrow (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_chan(evt_chan), .evt_tag(evt_tag), .evt_ring(evt_ring), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_n));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d, output logic [31:0] dn);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = rdata;
    dn = rdata_n;
  endtask

  task automatic read_cnt(output logic [63:0] c);
    logic [31:0] lo, hi, x;
    rd(2'd2, lo, x);
    rd(2'd3, hi, x);
    c = {16'b0, hi[15:0], lo};
  endtask

  task automatic cfg(logic [7:0] sel, logic [2:0] ch, logic tg, logic [1:0] rg);
    wr(2'd0, {10'b0, rg, tg, ch, 8'b0, sel});
  endtask

  task automatic clear_en();
    wr(2'd1, 32'd3);
  endtask

  task automatic send(logic [7:0] code, logic [2:0] ch, logic tg, logic [1:0] rg, int n);
    @(negedge clk);
    evt_valid = 1'b1; evt_code = code; evt_chan = ch; evt_tag = tg; evt_ring = rg;
    repeat (n) @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d, dn;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d, dn);
      check("R1 reset read", {32'b0, d}, 64'd0);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] d, dn;
    cfg(8'h5A, 3'd6, 1'b1, 2'd2);
    rd(2'd0, d, dn);
    check("R2 config readback", {32'b0, d}, 64'h002E_005A);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d, dn);
    check("R2 unused config bits", {32'b0, d}, 64'h003F_00FF);
    wr(2'd1, 32'd3);
    rd(2'd1, d, dn);
    check("R2 control readback", {32'b0, d}, 64'd1);
  endtask

  task automatic t_basic();
    logic [63:0] c;
    cfg(8'h10, 3'd0, 1'b0, 2'd0);
    clear_en();
    send(8'h10, 3'd2, 1'b0, 2'd1, 2);
    send(8'h10, 3'd7, 1'b1, 2'd2, 3);
    read_cnt(c);
    check("R3 basic count", c, 64'd5);
    send(8'h11, 3'd2, 1'b0, 2'd1, 3);
    send(8'h0F, 3'd2, 1'b0, 2'd1, 1);
    read_cnt(c);
    check("R11 other code ignored", c, 64'd5);
  endtask

  task automatic t_chan();
    logic [63:0] c;
    cfg(8'h20, 3'd2, 1'b0, 2'd0);
    clear_en();
    send(8'h20, 3'd2, 1'b0, 2'd0, 1);
    send(8'h20, 3'd4, 1'b0, 2'd0, 1);
    send(8'h20, 3'd2, 1'b0, 2'd0, 1);
    send(8'h20, 3'd7, 1'b0, 2'd0, 1);
    read_cnt(c);
    check("R4 request channel", c, 64'd2);
    cfg(8'h20, 3'd7, 1'b0, 2'd0);
    clear_en();
    send(8'h20, 3'd7, 1'b0, 2'd0, 2);
    send(8'h20, 3'd6, 1'b0, 2'd0, 1);
    read_cnt(c);
    check("R4 data channel", c, 64'd2);
    cfg(8'h20, 3'd3, 1'b0, 2'd0);
    clear_en();
    send(8'h20, 3'd3, 1'b0, 2'd0, 2);
    send(8'h20, 3'd0, 1'b0, 2'd0, 1);
    read_cnt(c);
    check("R4 unlisted channel code", c, 64'd0);
  endtask

  task automatic t_tag();
    logic [63:0] c;
    cfg(8'h30, 3'd0, 1'b1, 2'd0);
    clear_en();
    send(8'h30, 3'd0, 1'b1, 2'd0, 1);
    send(8'h30, 3'd0, 1'b0, 2'd0, 1);
    send(8'h30, 3'd0, 1'b1, 2'd0, 1);
    read_cnt(c);
    check("R5 tag gated", c, 64'd2);
    cfg(8'h30, 3'd0, 1'b0, 2'd0);
    send(8'h30, 3'd0, 1'b0, 2'd0, 2);
    read_cnt(c);
    check("R5 tag ignored when off", c, 64'd4);
  endtask

  task automatic t_ring();
    logic [63:0] c;
    cfg(8'h50, 3'd0, 1'b0, 2'b01);
    clear_en();
    send(8'h50, 3'd0, 1'b0, 2'b01, 2);
    send(8'h50, 3'd0, 1'b0, 2'b10, 1);
    read_cnt(c);
    check("R6 filter 01 extended", c, 64'd2);
    cfg(8'h50, 3'd0, 1'b0, 2'b11);
    clear_en();
    send(8'h50, 3'd0, 1'b0, 2'b01, 1);
    send(8'h50, 3'd0, 1'b0, 2'b10, 1);
    read_cnt(c);
    check("R6 filter 11 extended", c, 64'd1);
    cfg(8'h50, 3'd0, 1'b0, 2'b10);
    clear_en();
    send(8'h50, 3'd0, 1'b0, 2'b10, 2);
    send(8'h50, 3'd0, 1'b0, 2'b01, 1);
    read_cnt(c);
    check("R6 filter 10 normal", c, 64'd2);
    cfg(8'h50, 3'd0, 1'b0, 2'b00);
    clear_en();
    send(8'h50, 3'd0, 1'b0, 2'b01, 1);
    send(8'h50, 3'd0, 1'b0, 2'b10, 1);
    read_cnt(c);
    check("R6 filter 00 both", c, 64'd2);
  endtask

  task automatic t_window();
    logic [63:0] c;
    cfg(8'h46, 3'd0, 1'b0, 2'b10);
    clear_en();
    send(8'h46, 3'd0, 1'b0, 2'b01, 1);
    read_cnt(c);
    check("R7 code 0x46 unfiltered", c, 64'd1);
    cfg(8'h5A, 3'd0, 1'b0, 2'b10);
    clear_en();
    send(8'h5A, 3'd0, 1'b0, 2'b01, 1);
    read_cnt(c);
    check("R7 code 0x5A unfiltered", c, 64'd1);
    cfg(8'h47, 3'd0, 1'b0, 2'b10);
    clear_en();
    send(8'h47, 3'd0, 1'b0, 2'b01, 1);
    read_cnt(c);
    check("R7 code 0x47 filtered", c, 64'd0);
    cfg(8'h59, 3'd0, 1'b0, 2'b10);
    clear_en();
    send(8'h59, 3'd0, 1'b0, 2'b01, 1);
    send(8'h59, 3'd0, 1'b0, 2'b10, 1);
    read_cnt(c);
    check("R7 code 0x59 filtered", c, 64'd1);
  endtask

  task automatic t_enable();
    logic [63:0] c;
    cfg(8'h22, 3'd0, 1'b0, 2'd0);
    clear_en();
    send(8'h22, 3'd0, 1'b0, 2'd0, 4);
    wr(2'd1, 32'd0);
    send(8'h22, 3'd0, 1'b0, 2'd0, 3);
    read_cnt(c);
    check("R8 disabled holds", c, 64'd4);
    wr(2'd1, 32'd1);
    send(8'h22, 3'd0, 1'b0, 2'd0, 1);
    read_cnt(c);
    check("R8 re-enabled resumes", c, 64'd5);
  endtask

  task automatic t_clear();
    logic [63:0] c;
    cfg(8'h33, 3'd0, 1'b0, 2'd0);
    clear_en();
    send(8'h33, 3'd0, 1'b0, 2'd0, 6);
    @(negedge clk);
    evt_valid = 1'b1; evt_code = 8'h33;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd3;
    @(negedge clk);
    evt_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    read_cnt(c);
    check("R9 clear beats event", c, 64'd0);
    send(8'h33, 3'd0, 1'b0, 2'd0, 1);
    read_cnt(c);
    check("R9 count after clear", c, 64'd1);
  endtask

  task automatic t_ovf();
    logic [31:0] d, dn;
    logic [63:0] c;
    cfg(8'h3C, 3'd0, 1'b0, 2'd0);
    clear_en();
    send(8'h3C, 3'd0, 1'b0, 2'd0, 63);
    rd(2'd2, d, dn);
    check("R10 narrow at max", {32'b0, dn}, 64'd63);
    rd(2'd3, d, dn);
    check("R10 no overflow yet", {32'b0, dn}, 64'd0);
    send(8'h3C, 3'd0, 1'b0, 2'd0, 1);
    rd(2'd2, d, dn);
    check("R10 wrap to zero", {32'b0, dn}, 64'd0);
    rd(2'd3, d, dn);
    check("R10 overflow set", {32'b0, dn}, 64'h8000_0000);
    check("R10 wide high word clean", {32'b0, d}, 64'd0);
    send(8'h3C, 3'd0, 1'b0, 2'd0, 1);
    rd(2'd3, d, dn);
    check("R10 overflow sticky", {32'b0, dn}, 64'h8000_0000);
    read_cnt(c);
    check("R3 wide count", c, 64'd65);
    clear_en();
    rd(2'd3, d, dn);
    check("R9 clear drops overflow", {32'b0, dn}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_basic();
    t_chan();
    t_tag();
    t_ring();
    t_window();
    t_enable();
    t_clear();
    t_ovf();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule